// File: doc/BRIEF.md
# Filter Microprogram Boot Loader

After a reset, this block copies a small filter microprogram from an external nonvolatile store into a local program memory. The microprogram drives a multiplier-free FIR engine. Both memories hold 32 words of 6 bits, and a 5-bit address selects each word.

Word 0 of the store is not an operation. It gives the number of operations that follow, so the loader reads it first. It clamps that number to the largest usable address, then fetches words 1 through that count in ascending order. The store answers with one cycle of read latency, and each returned word is written to the same address in program memory. When the last word is written, the loader raises a ready flag. The flag holds until the next reset, and the FIR engine waits for it.

The engine reads the program memory through a read port on this block. Each word is split into four fields: a no-operand flag, a subtract flag, a shift-after-accumulate flag and a 3-bit sample address.

Top module: `uprog_loader`

## Requirements
- R1: While reset is high and on the first cycle after it, `ready`, `src_rd_en` and `op_count` are all 0, and the program-memory read outputs are 0.
- R2: The first request to the store is for address 0. The word returned there is taken as the operation count and appears on `op_count`.
- R3: A stored count above 31 is clamped to 31. Counts of 0 to 31 are used as given.
- R4: For count N, the store is read at addresses 0, 1, ..., N in that order. Each address is read exactly once, and no address above N is requested.
- R5: Each word returned for address k (1 ≤ k ≤ N) is written to program-memory address k. A later read of address k returns that word.
- R6: A program word's bit 5 drives `pm_zero`, bit 4 drives `pm_sign`, bit 3 drives `pm_shift`, and bits 2:0 drive `pm_daddr`. The read data appears one cycle after `pm_rd_en` is sampled high.
- R7: Count the clock edges from the first edge with reset low. `ready` rises on edge N+4 for N ≥ 1, or on edge 3 for N = 0. It then stays high until reset, with no further store reads and `op_count` unchanged.
- R8: Program-memory reads requested while `ready` is low are ignored, and the read outputs keep their reset value of 0.
- R9: A new reset restarts loading from address 0 with whatever the store now holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_rd_en | output | 1 | Read request to the external store |
| src_addr | output | 5 | Store word address |
| src_data | input | 6 | Store read data, valid one cycle after the request |
| pm_rd_en | input | 1 | Engine read request to program memory |
| pm_rd_addr | input | 5 | Engine read address |
| pm_zero | output | 1 | Field: no operand |
| pm_sign | output | 1 | Field: subtract the operand |
| pm_shift | output | 1 | Field: shift right after accumulating |
| pm_daddr | output | 3 | Field: sample address |
| op_count | output | 5 | Captured and clamped operation count |
| ready | output | 1 | Loading finished |

## Verification
Some rules are checked on every cycle by the assertions:
- No store address above the captured count is ever requested.
- No program-memory write happens once `ready` is high.
- `ready` never falls without a reset, and `op_count` is frozen once ready.
- Read outputs do not move while loading.

Other behaviour only the bench scenarios can show:
- the exact read order,
- the clamping of large counts,
- the ready latency for each count,
- the correct field split of every copied word, against a modelled store filled with random contents.

// File: rtl/uprog_pkg.sv
package uprog_pkg;

  typedef enum logic [2:0] {
    LD_START,
    LD_CNT,
    LD_CNTWAIT,
    LD_COPY,
    LD_DONE
  } ld_state_t;

endpackage

// File: rtl/uprog_ram.sv
module uprog_ram #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/uprog_seq.sv
module uprog_seq
  import uprog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] src_word,
  output logic              src_rd_en,
  output logic [ADDR_W-1:0] src_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] op_count,
  output logic              ready
);
  localparam int              CNT_MAX   = (1 << ADDR_W) - 1;
  localparam logic [WORD_W-1:0] CNT_MAX_W = WORD_W'(CNT_MAX);

  ld_state_t         state;
  logic              pend;
  logic [ADDR_W-1:0] cnt_clamped;

  always_comb begin
    if (src_word > CNT_MAX_W) cnt_clamped = ADDR_W'(CNT_MAX);
    else                      cnt_clamped = src_word[ADDR_W-1:0];
  end

  assign wr_en = pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LD_START;
      src_rd_en <= 1'b0;
      src_addr  <= '0;
      pend      <= 1'b0;
      wr_addr   <= '0;
      op_count  <= '0;
      ready     <= 1'b0;
    end else begin
      case (state)
        LD_START: begin
          src_rd_en <= 1'b1;
          src_addr  <= '0;
          state     <= LD_CNT;
        end
        LD_CNT: begin
          src_rd_en <= 1'b0;
          state     <= LD_CNTWAIT;
        end
        LD_CNTWAIT: begin
          op_count <= cnt_clamped;
          if (cnt_clamped == '0) begin
            ready <= 1'b1;
            state <= LD_DONE;
          end else begin
            src_rd_en <= 1'b1;
            src_addr  <= ADDR_W'(1);
            state     <= LD_COPY;
          end
        end
        LD_COPY: begin
          pend    <= src_rd_en;
          wr_addr <= src_addr;
          if (src_rd_en) begin
            if (src_addr == op_count) src_rd_en <= 1'b0;
            else src_addr <= src_addr + ADDR_W'(1);
          end else if (pend) begin
            ready <= 1'b1;
            state <= LD_DONE;
          end
        end
        default: begin
          src_rd_en <= 1'b0;
          pend      <= 1'b0;
        end
      endcase
    end
  end

  // R4
  addr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    src_rd_en |-> (src_addr <= op_count));

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R7
  ready_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> !src_rd_en);

  // R7
  count_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(op_count));

  // R5
  no_late_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !ready);

endmodule

// File: rtl/uprog_loader.sv
module uprog_loader #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  output logic              src_rd_en,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [WORD_W-1:0] src_data,
  input  logic              pm_rd_en,
  input  logic [ADDR_W-1:0] pm_rd_addr,
  output logic              pm_zero,
  output logic              pm_sign,
  output logic              pm_shift,
  output logic [WORD_W-4:0] pm_daddr,
  output logic [ADDR_W-1:0] op_count,
  output logic              ready
);
  localparam int DADDR_W = WORD_W - 3;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] rd_word;
  logic              rd_gate;

  assign rd_gate = pm_rd_en & ready;

  uprog_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .src_word  (src_data),
    .src_rd_en (src_rd_en),
    .src_addr  (src_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .op_count  (op_count),
    .ready     (ready)
  );

  uprog_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) ram_i (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (src_data),
    .re    (rd_gate),
    .raddr (pm_rd_addr),
    .rdata (rd_word)
  );

  assign pm_zero  = rd_word[WORD_W-1];
  assign pm_sign  = rd_word[WORD_W-2];
  assign pm_shift = rd_word[WORD_W-3];
  assign pm_daddr = rd_word[DADDR_W-1:0];

  // R8
  quiet_read_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(rd_word));

endmodule

// File: tb/uprog_loader_tb.sv
module uprog_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_rd_en;
  logic [4:0] src_addr;
  logic [5:0] src_data = '0;
  logic       pm_rd_en = 1'b0;
  logic [4:0] pm_rd_addr = '0;
  logic       pm_zero, pm_sign, pm_shift;
  logic [2:0] pm_daddr;
  logic [4:0] op_count;
  logic       ready;

  logic [5:0] rom [32];
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  int exp_addr = 0;
  int reads = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uprog_loader dut_i (
    .clk(clk), .rst(rst),
    .src_rd_en(src_rd_en), .src_addr(src_addr), .src_data(src_data),
    .pm_rd_en(pm_rd_en), .pm_rd_addr(pm_rd_addr),
    .pm_zero(pm_zero), .pm_sign(pm_sign), .pm_shift(pm_shift),
    .pm_daddr(pm_daddr), .op_count(op_count), .ready(ready)
  );

  // external store model: one cycle read latency
  always @(posedge clk) if (src_rd_en) src_data <= rom[src_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp_cnt(input int w);
    return (w > 31) ? 31 : w;
  endfunction

  function automatic int exp_latency(input int n);
    return (n == 0) ? 3 : n + 4;
  endfunction

  always @(negedge clk) begin
    if (mon_on && !rst && src_rd_en) begin
      check(int'(src_addr) == exp_addr, "R4 read order", int'(src_addr), exp_addr);
      exp_addr++;
      reads++;
    end
  end

  task automatic run_trial(input int cnt_word);
    int n;
    int lat;
    n = clamp_cnt(cnt_word);
    rst = 1'b1;
    pm_rd_en = 1'b0;
    rom[0] = 6'(cnt_word);
    for (int k = 1; k < 32; k++) rom[k] = 6'($urandom_range(0, 63));
    repeat (3) @(negedge clk);
    check(!ready && !src_rd_en && op_count == 0 &&
          {pm_zero, pm_sign, pm_shift, pm_daddr} == 6'd0,
          "R1 reset state", int'({ready, src_rd_en}), 0);
    exp_addr = 0;
    reads = 0;
    mon_on = 1'b1;
    pm_rd_en = 1'b1;
    pm_rd_addr = 5'($urandom_range(0, 31));
    rst = 1'b0;
    lat = 0;
    while (!ready && lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 1)
        check(!ready && src_rd_en && src_addr == 0, "R1 R2 first request",
              int'(src_addr), 0);
      if (!ready && {pm_zero, pm_sign, pm_shift, pm_daddr} != 6'd0)
        check(1'b0, "R8 read before ready",
              int'({pm_zero, pm_sign, pm_shift, pm_daddr}), 0);
    end
    check(lat == exp_latency(n), "R7 ready latency", lat, exp_latency(n));
    check(int'(op_count) == n, "R2 R3 R9 op_count", int'(op_count), n);
    check({pm_zero, pm_sign, pm_shift, pm_daddr} == 6'd0, "R8 outputs held",
          int'({pm_zero, pm_sign, pm_shift, pm_daddr}), 0);
    pm_rd_en = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(ready && !src_rd_en && int'(op_count) == n, "R7 ready hold",
            int'({ready, src_rd_en}), 2);
    end
    check(reads == n + 1, "R4 read count", reads, n + 1);
    mon_on = 1'b0;
    for (int k = 1; k <= n; k++) begin
      pm_rd_en = 1'b1;
      pm_rd_addr = 5'(k);
      @(negedge clk);
      pm_rd_en = 1'b0;
      check({pm_zero, pm_sign, pm_shift, pm_daddr} == rom[k], "R5 copied word",
            int'({pm_zero, pm_sign, pm_shift, pm_daddr}), int'(rom[k]));
      if (k == 1) begin
        check(pm_zero == rom[k][5] && pm_sign == rom[k][4] &&
              pm_shift == rom[k][3] && pm_daddr == rom[k][2:0], "R6 field split",
              int'({pm_zero, pm_sign, pm_shift, pm_daddr}), int'(rom[k]));
      end
      check(ready, "R7 ready during reads", int'(ready), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_trial(28);
    run_trial(0);
    run_trial(1);
    run_trial(31);
    run_trial(32);
    run_trial(63);
    run_trial(2);
    for (int t = 0; t < 8; t++) run_trial($urandom_range(0, 63));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule